// File: doc/BRIEF.md
# Drive Indicator Serial Link Transmitter

This block holds three indicator lights (fault, locate, activity) for each of up to eight disk ports. It sends all of them to a backplane LED controller over three output wires: a shift clock, a frame-load strobe and a data line. A port-side agent presents a request made of a port number and a 32-bit status word. The block turns the status word into that port's three indicator bits. It places the bits at the slot that a programmable port-to-slot table assigns to the port, then transmits a complete frame of the updated pattern.

The indicator bits are sticky. A nonzero status word can only turn bits on. A status word of exactly zero turns off all three bits of that port. A request is accepted through a valid/ready handshake, and ready is low while a frame is being sent. A request whose slot-select field is out of range is consumed and flagged, and it changes nothing. The phase length of the serial clock is counted in system clocks. The number of ports carried in a frame is a runtime input.

Top module: `drive_led_serializer`

## Requirements
- R1: After synchronous active-low reset, `led_clk`, `led_load` and `led_data` are all 1, `req_ready` is 1, `req_err` is 0, and every table entry and every pattern bit is 0.
- R2: For a nonzero accepted status word, the activity bit is set when status bit 20 or bit 21 is 1, locate is set when bit 19 is 1, and fault is set when bit 22 is 1. No pattern bit is ever cleared by a nonzero word.
- R3: An accepted status word of zero clears the fault, locate and activity bits of the addressed port's slot and leaves all other bits unchanged.
- R4: A port's bits sit at pattern index 3*slot+offset, with fault at offset 0, locate at offset 1 and activity at offset 2. The slot is the table entry of the request's port.
- R5: A cycle with `map_we` high writes `map_slot` into the table entry of `map_port`. Later requests for that port use the new slot.
- R6: A frame starts on the cycle after acceptance with `led_load` and `led_clk` high. `led_load` stays high for one full clock period (one high phase, then one low phase) and falls on the same cycle that `led_clk` rises for the first data bit.
- R7: After the load period the frame carries 3*N data bits, pattern bit 0 first. Each bit is on `led_data` when `led_clk` rises and stays stable through the high phase.
- R8: Every high phase and every low phase of `led_clk` inside a frame lasts exactly PHASE_CLKS system clocks.
- R9: N is `n_ports` clamped to the range 1..MAX_PORTS. A value of 0 sends 3 bits, and a value above MAX_PORTS sends 3*MAX_PORTS bits.
- R10: A request whose status bits 15:8 hold a value of MAX_PORTS or more is consumed and pulses `req_err` for the one cycle after the handshake. It starts no frame and changes no pattern bit. A value of MAX_PORTS-1 is accepted normally.
- R11: `req_ready` is low from the cycle after a frame is accepted until the frame ends. A request presented meanwhile waits and is taken once ready returns. The pattern does not change while ready is low.
- R12: At the end of a frame `led_clk` and `led_load` stay low and `led_data` keeps the last bit sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_port | input | 3 | Port number of the request |
| req_status | input | 32 | Status word to decode |
| req_err | output | 1 | One-cycle pulse: last request rejected |
| map_we | input | 1 | Table write enable |
| map_port | input | 3 | Table entry to write |
| map_slot | input | 3 | Slot value to store |
| n_ports | input | 4 | Number of ports carried per frame (clamped) |
| led_clk | output | 1 | Serial shift clock |
| led_load | output | 1 | Frame-load strobe |
| led_data | output | 1 | Serial data |

## Verification
The bench builds the block with MAX_PORTS at its default of 8 and PHASE_CLKS reduced to 3. With these values a full 24-bit frame takes about 150 cycles, so many frames fit in one run. The short phase still leaves room to count the exact length of every high and low phase. The run uses the full table and all eight slots, so it reaches the clamp of `n_ports` at both ends and the slot-select boundary at 7 (accepted) and 8 (rejected).

// File: rtl/sgpio_led_pkg.sv
// Shared constants and types of the drive indicator serial transmitter.
// Assumes a 32-bit status word, with the decoded field positions given below.
package sgpio_led_pkg;

    // Number of indicator bits carried per port.
    localparam int IND_BITS   = 3;
    // Offsets of the indicators inside one port's group.
    localparam int OFS_FAULT  = 0;
    localparam int OFS_LOCATE = 1;
    localparam int OFS_ACT    = 2;

    // Status word layout.
    localparam int STATUS_W   = 32;
    localparam int BIT_ACT_A  = 20;
    localparam int BIT_ACT_B  = 21;
    localparam int BIT_LOCATE = 19;
    localparam int BIT_FAULT  = 22;
    localparam int SEL_LSB    = 8;
    localparam int SEL_MSB    = 15;

    // States of the frame sequencer.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LD_HI,
        ST_LD_LO,
        ST_BIT_HI,
        ST_BIT_LO
    } ser_state_e;

endpackage

// File: rtl/led_slot_map.sv
// Port-to-slot table: one writable slot number per port.
// Assumes MAX_PORTS >= 2. Every entry resets to slot 0.
module led_slot_map #(
    parameter int MAX_PORTS = 8,
    localparam int SW = $clog2(MAX_PORTS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [SW-1:0] wr_port,
    input  logic [SW-1:0] wr_slot,
    input  logic [SW-1:0] rd_port,
    output logic [SW-1:0] rd_slot
);

    logic [SW-1:0] tbl [MAX_PORTS];

    // Reset all entries to zero, otherwise write one entry on request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MAX_PORTS; i++) tbl[i] <= '0;
        end else if (wr_en) begin
            tbl[wr_port] <= wr_slot;
        end
    end

    // Combinational lookup of the requesting port's slot.
    assign rd_slot = tbl[rd_port];

endmodule

// File: rtl/led_indicator_pattern.sv
// Indicator pattern register. It decodes a status word into fault, locate
// and activity, and merges them into the group of the addressed slot.
// A zero word clears the group. A nonzero word only sets bits.
// pattern_nxt is the value the register takes on the update edge; the
// frame sequencer uses it as its snapshot.
module led_indicator_pattern
    import sgpio_led_pkg::*;
#(
    parameter int MAX_PORTS = 8,
    localparam int SW = $clog2(MAX_PORTS),
    localparam int PW = IND_BITS * MAX_PORTS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                upd_en,
    input  logic [SW-1:0]       slot,
    input  logic [STATUS_W-1:0] status,
    output logic [PW-1:0]       pattern,
    output logic [PW-1:0]       pattern_nxt
);

    logic is_zero;
    logic dec_act;
    logic dec_loc;
    logic dec_flt;

    // Field decode of the status word.
    always_comb begin
        is_zero = (status == '0);
        dec_act = status[BIT_ACT_A] | status[BIT_ACT_B];
        dec_loc = status[BIT_LOCATE];
        dec_flt = status[BIT_FAULT];
    end

    // Next pattern: clear or set the indicator group of the selected slot.
    always_comb begin
        pattern_nxt = pattern;
        for (int i = 0; i < MAX_PORTS; i++) begin
            if (upd_en && slot == SW'(i)) begin
                if (is_zero) begin
                    pattern_nxt[IND_BITS*i + OFS_FAULT]  = 1'b0;
                    pattern_nxt[IND_BITS*i + OFS_LOCATE] = 1'b0;
                    pattern_nxt[IND_BITS*i + OFS_ACT]    = 1'b0;
                end else begin
                    if (dec_flt) pattern_nxt[IND_BITS*i + OFS_FAULT]  = 1'b1;
                    if (dec_loc) pattern_nxt[IND_BITS*i + OFS_LOCATE] = 1'b1;
                    if (dec_act) pattern_nxt[IND_BITS*i + OFS_ACT]    = 1'b1;
                end
            end
        end
    end

    // Pattern register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) pattern <= '0;
        else        pattern <= pattern_nxt;
    end

    // R2: a nonzero word never clears a bit.
    p_sticky_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !is_zero) |=> ((pattern & $past(pattern)) == $past(pattern)));

    // R3: a zero word leaves the addressed group all-zero.
    p_zero_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && is_zero) |=>
            (((pattern >> (IND_BITS * int'($past(slot)))) & PW'(7)) == '0));

endmodule

// File: rtl/led_frame_shifter.sv
// Frame sequencer for the three-wire output. On start it captures a pattern
// snapshot and a bit count. It sends one load period (load high through one
// clock high and low phase), then the bits LSB first. Data changes on the
// falling clock, so each bit is settled before its rising clock. Assumes
// PHASE_CLKS >= 1 and nbits >= 1.
module led_frame_shifter
    import sgpio_led_pkg::*;
#(
    parameter int MAX_PORTS  = 8,
    parameter int PHASE_CLKS = 12500,
    localparam int PW  = IND_BITS * MAX_PORTS,
    localparam int BCW = $clog2(PW + 1),
    localparam int TW  = (PHASE_CLKS > 1) ? $clog2(PHASE_CLKS) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [PW-1:0]  frame_in,
    input  logic [BCW-1:0] nbits,
    output logic           ready,
    output logic           sclk,
    output logic           sload,
    output logic           sdata
);

    localparam logic [TW-1:0] T_RELOAD = TW'(PHASE_CLKS - 1);

    ser_state_e     state;
    logic [TW-1:0]  timer;
    logic [BCW-1:0] remain;
    logic [PW-1:0]  shreg;
    logic           phase_end;

    assign phase_end = (timer == '0);
    assign ready     = (state == ST_IDLE);

    // Sequencer: phase timer, line levels and shift register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            timer  <= '0;
            remain <= '0;
            shreg  <= '0;
            sclk   <= 1'b1;
            sload  <= 1'b1;
            sdata  <= 1'b1;
        end else begin
            if (state != ST_IDLE && !phase_end) timer <= timer - 1'b1;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        state  <= ST_LD_HI;
                        timer  <= T_RELOAD;
                        shreg  <= frame_in;
                        remain <= nbits;
                        sload  <= 1'b1;
                        sclk   <= 1'b1;
                    end
                end
                ST_LD_HI: begin
                    if (phase_end) begin
                        state <= ST_LD_LO;
                        timer <= T_RELOAD;
                        sclk  <= 1'b0;
                        sdata <= shreg[0];
                    end
                end
                ST_LD_LO: begin
                    if (phase_end) begin
                        state <= ST_BIT_HI;
                        timer <= T_RELOAD;
                        sload <= 1'b0;
                        sclk  <= 1'b1;
                    end
                end
                ST_BIT_HI: begin
                    if (phase_end) begin
                        state  <= ST_BIT_LO;
                        timer  <= T_RELOAD;
                        sclk   <= 1'b0;
                        remain <= remain - 1'b1;
                        shreg  <= shreg >> 1;
                        if (remain > BCW'(1)) sdata <= shreg[1];
                    end
                end
                ST_BIT_LO: begin
                    if (phase_end) begin
                        timer <= T_RELOAD;
                        if (remain == '0) begin
                            state <= ST_IDLE;
                        end else begin
                            state <= ST_BIT_HI;
                            sclk  <= 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R7: data holds still while the clock is high in the data part.
    p_data_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!sload && sclk && $past(sclk)) |-> $stable(sdata));

    // R6: load drops only together with the first data clock rising.
    p_load_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sload) |-> $rose(sclk));

    // R1/R6: a frame begins with both load and clock high.
    p_frame_open_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && start) |=> (sload && sclk));

endmodule

// File: rtl/drive_led_serializer.sv
// Top of the drive indicator transmitter. It handles the request handshake,
// the slot-select range check and the port-count clamp, and it joins the
// slot table, the pattern register and the frame sequencer. A request is
// taken only while no frame is running. Pattern update and frame snapshot
// happen on the same edge.
module drive_led_serializer
    import sgpio_led_pkg::*;
#(
    parameter int MAX_PORTS  = 8,
    parameter int PHASE_CLKS = 12500,
    localparam int SW  = $clog2(MAX_PORTS),
    localparam int NPW = $clog2(MAX_PORTS + 1),
    localparam int PW  = IND_BITS * MAX_PORTS,
    localparam int BCW = $clog2(PW + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [SW-1:0]       req_port,
    input  logic [STATUS_W-1:0] req_status,
    output logic                req_err,
    input  logic                map_we,
    input  logic [SW-1:0]       map_port,
    input  logic [SW-1:0]       map_slot,
    input  logic [NPW-1:0]      n_ports,
    output logic                led_clk,
    output logic                led_load,
    output logic                led_data
);

    logic            accept;
    logic            sel_bad;
    logic            upd_en;
    logic [SW-1:0]   slot;
    logic [NPW-1:0]  n_eff;
    logic [BCW-1:0]  nbits;
    logic [PW-1:0]   pat_q;
    logic [PW-1:0]   pat_nxt;
    logic [SEL_MSB-SEL_LSB:0] sel_field;

    // Handshake and slot-select range check.
    always_comb begin
        sel_field = req_status[SEL_MSB:SEL_LSB];
        accept    = req_valid && req_ready;
        sel_bad   = (32'(sel_field) >= 32'(MAX_PORTS));
        upd_en    = accept && !sel_bad;
    end

    // Clamp the port count into 1..MAX_PORTS and derive the bit count.
    always_comb begin
        if (n_ports == '0)                     n_eff = NPW'(1);
        else if (32'(n_ports) > 32'(MAX_PORTS)) n_eff = NPW'(MAX_PORTS);
        else                                   n_eff = n_ports;
        nbits = BCW'(IND_BITS * 32'(n_eff));
    end

    // One-cycle error pulse for a rejected request.
    always_ff @(posedge clk) begin
        if (!rst_n) req_err <= 1'b0;
        else        req_err <= accept && sel_bad;
    end

    led_slot_map #(.MAX_PORTS(MAX_PORTS)) u_map (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (map_we),
        .wr_port (map_port),
        .wr_slot (map_slot),
        .rd_port (req_port),
        .rd_slot (slot)
    );

    led_indicator_pattern #(.MAX_PORTS(MAX_PORTS)) u_pat (
        .clk         (clk),
        .rst_n       (rst_n),
        .upd_en      (upd_en),
        .slot        (slot),
        .status      (req_status),
        .pattern     (pat_q),
        .pattern_nxt (pat_nxt)
    );

    led_frame_shifter #(.MAX_PORTS(MAX_PORTS), .PHASE_CLKS(PHASE_CLKS)) u_shf (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (upd_en),
        .frame_in (pat_nxt),
        .nbits    (nbits),
        .ready    (req_ready),
        .sclk     (led_clk),
        .sload    (led_load),
        .sdata    (led_data)
    );

    // R10: an error pulse always follows a handshake.
    p_err_after_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> $past(req_valid && req_ready));

    // R10: a rejected request leaves the pattern untouched.
    p_reject_no_change_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && sel_bad) |=> $stable(pat_q));

    // R11: the pattern is frozen while a frame is running.
    p_busy_freeze_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> $stable(pat_q));

endmodule

// File: tb/drive_led_serializer_bench.sv
`timescale 1ns/1ps
module drive_led_serializer_bench;

    localparam int MAXP  = 8;
    localparam int PHASE = 3;

    typedef struct {
        logic [23:0] pat;
        int          nb;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_port = '0;
    logic [31:0] req_status = '0;
    logic        req_err;
    logic        map_we = 1'b0;
    logic [2:0]  map_port = '0;
    logic [2:0]  map_slot = '0;
    logic [3:0]  n_ports = 4'd5;
    logic        led_clk, led_load, led_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    exp_t        q[$];
    logic [23:0] m_pat = '0;
    int          m_map [MAXP];

    always #2 clk = ~clk;

    drive_led_serializer #(.MAX_PORTS(MAXP), .PHASE_CLKS(PHASE)) u_drive_led_serializer (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_port(req_port), .req_status(req_status), .req_err(req_err),
        .map_we(map_we), .map_port(map_port), .map_slot(map_slot),
        .n_ports(n_ports),
        .led_clk(led_clk), .led_load(led_load), .led_data(led_data)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, expv, $time);
        end
    endtask

    // Write one table entry and mirror it in the model (R5).
    task automatic map_write(input int p, input int s);
        @(negedge clk);
        map_we = 1'b1; map_port = 3'(p); map_slot = 3'(s);
        @(negedge clk);
        map_we = 1'b0;
        m_map[p] = s;
    endtask

    // Driver: compute expectation, push, then hold the request until taken.
    task automatic send(input int p, input logic [31:0] st);
        int nclamp;
        bit bad;
        int base;
        bad  = (st[15:8] >= 8'(MAXP));
        nclamp = (n_ports == 0) ? 1 : ((n_ports > MAXP) ? MAXP : int'(n_ports));
        if (!bad) begin
            base = 3 * m_map[p];
            if (st == 0) begin
                m_pat[base] = 0; m_pat[base+1] = 0; m_pat[base+2] = 0;
            end else begin
                if (st[22])          m_pat[base]   = 1;
                if (st[19])          m_pat[base+1] = 1;
                if (st[20] | st[21]) m_pat[base+2] = 1;
            end
            q.push_back('{pat: m_pat, nb: 3 * nclamp});
        end
        @(negedge clk);
        req_valid = 1'b1; req_port = 3'(p); req_status = st;
        while (!req_ready) begin
            chk(req_err == 1'b0, "R11 no error while held", req_err, 0);
            @(negedge clk);
        end
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_err == bad, bad ? "R10 reject flag" : "R10 no flag on good request", req_err, bad);
        if (!bad) chk(req_ready == 1'b0, "R11 busy after accept", req_ready, 0);
        else      chk(req_ready == 1'b1, "R10 reject starts no frame", req_ready, 1);
    endtask

    // Monitor: pops expectations at frame start and compares the wire traffic.
    initial begin
        bit   prev_clk, prev_load, prev_ready, framing;
        int   run, fcyc, got_n;
        logic [23:0] gotv;
        exp_t cur;
        prev_clk = 1; prev_load = 1; prev_ready = 1; framing = 0;
        run = 0; fcyc = 0; got_n = 0; gotv = '0;
        cur = '{pat: '0, nb: 0};
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                prev_clk = 1; prev_load = 1; prev_ready = 1; framing = 0;
                continue;
            end
            if (prev_ready && !req_ready) begin
                framing = 1; run = 1; fcyc = 0; got_n = 0; gotv = '0;
                if (q.size() == 0) begin
                    chk(0, "R10 unexpected frame", 1, 0);
                    cur = '{pat: '0, nb: 0};
                end else cur = q.pop_front();
                chk(led_load && led_clk, "R6 frame opens with load and clock high", {led_load, led_clk}, 3);
            end else if (!prev_ready && req_ready && framing) begin
                framing = 0;
                chk(run == PHASE, "R8 final low phase length", run, PHASE);
                chk(got_n == cur.nb, "R9 bit count", got_n, cur.nb);
                if (cur.nb > 0)
                    chk(!led_clk && !led_load && led_data == cur.pat[cur.nb-1],
                        "R12 idle levels after frame", {led_clk, led_load, led_data},
                        {2'b00, cur.pat[cur.nb-1]});
            end else if (framing) begin
                fcyc++;
                if (led_clk != prev_clk) begin
                    chk(run == PHASE, "R8 phase length", run, PHASE);
                    run = 1;
                end else run++;
                if (prev_load && !led_load) begin
                    chk(fcyc == 2 * PHASE, "R6 load spans one clock period", fcyc, 2 * PHASE);
                    chk(led_clk && !prev_clk, "R6 load falls with first rising clock", led_clk, 1);
                end
                if (led_clk && !prev_clk && !led_load) begin
                    if (got_n < 24) gotv[got_n] = led_data;
                    got_n++;
                    if (got_n == cur.nb)
                        chk(gotv == (cur.pat & ((24'd1 << cur.nb) - 24'd1)),
                            "R7 R4 R2 R3 frame contents LSB first", gotv,
                            cur.pat & ((24'd1 << cur.nb) - 24'd1));
                end
            end
            prev_clk = led_clk; prev_load = led_load; prev_ready = req_ready;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hang expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < MAXP; i++) m_map[i] = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset levels.
        chk(led_clk && led_load && led_data, "R1 lines high after reset",
            {led_clk, led_load, led_data}, 7);
        chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
        chk(req_err == 1'b0, "R1 no error after reset", req_err, 0);

        // R1/R4: table at reset maps every port to slot 0.
        send(3, 32'h0040_0000);

        // R5: program a remapping table.
        map_write(0, 4); map_write(1, 0); map_write(2, 1); map_write(3, 2);
        map_write(4, 3); map_write(5, 5); map_write(6, 6); map_write(7, 7);

        // R2 R4: each indicator through the table.
        send(0, 32'h0010_0000);
        send(1, 32'h0020_0000);
        send(2, 32'h0008_0000);
        send(4, 32'h0048_0000);
        // R2: sticky; a word with no indicator bits changes nothing.
        send(1, 32'h0008_0000);
        send(2, 32'h0000_0001);
        // R3: zero word clears slot 4 group only.
        send(0, 32'h0000_0000);
        // R10: boundary 7 accepted, 8 and 255 rejected.
        send(3, 32'h0040_0700);
        send(2, 32'h0040_0800);
        send(5, 32'h0030_FF00);
        // R11: back-to-back requests, the second is held.
        send(5, 32'h0020_0000);
        send(6, 32'h0040_0000);
        // R9: clamp both ends.
        n_ports = 4'd0;
        send(7, 32'h0040_0000);
        n_ports = 4'd12;
        send(7, 32'h0008_0000);
        n_ports = 4'd8;
        send(0, 32'h0070_0000);

        while (!req_ready || q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(q.size() == 0, "R11 all frames seen", q.size(), 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule